// File: doc/BRIEF.md
# Byte-Lane Static Memory Core

This block is a synchronous, synthesizable model of a word-organized static memory that sits behind a pair of chip selects of opposite polarity. Each write or read can be limited to the upper byte, the lower byte or both. Each byte lane has its own drive flag, which stands in for a tristate enable on a bidirectional pin. A registered standby flag reports whether the selects and byte enables leave the memory deselected, in which case it draws standby power.

On every clock edge the block decodes its control inputs into one of four modes: standby, output-disabled, read or write. In write mode only the enabled lanes of the addressed word are updated. Write enable wins over output enable, so a write happens no matter what output enable is doing. In read mode the addressed word is captured into an output register, and the drive flags are updated in the same cycle, so read data appears one cycle after the request. The address port is 19 bits wide. The stored depth is set by a parameter: its default keeps 1K words, and setting it to 19 gives the full 512K-word space.

Top module: `sram_core`

## Requirements
- R1: The memory is deselected when chip_sel_n is 1, when chip_sel is 0, or when both bits of lane_en_n are 1. The cycle after a deselected request, in_standby is 1 and both lane_drv bits are 0.
- R2: A read is a selected request with wr_n = 1 and rd_oe_n = 0. The cycle after it, lane_drv equals the inverse of lane_en_n. Each driven lane of rd_word holds the stored byte of the addressed word: bit 0 of lane_en_n and lane_drv belong to bits 7:0, and bit 1 belongs to bits 15:8.
- R3: Whenever a lane_drv bit is 0, the matching byte of rd_word is 0.
- R4: A write is a selected request with wr_n = 0, whatever rd_oe_n is. The enabled bytes of the addressed word are stored at that clock edge. The cycle after it, both lane_drv bits are 0 and in_standby is 0.
- R5: During a write, a lane whose lane_en_n bit is 1 keeps its stored byte unchanged.
- R6: A selected request with wr_n = 1 and rd_oe_n = 1 gives both lane_drv bits 0 and in_standby 0 in the next cycle.
- R7: While rst_n is 0, lane_drv is 0, rd_word is 0 and in_standby is 1.
- R8: Only the low MEM_AW address bits (default 10) select a word. Addresses that differ only above those bits reach the same word.
- R9: A write strobe (wr_n = 0) given while the memory is deselected, by any of the three conditions in R1, leaves the stored data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the output registers |
| addr | input | 19 | Word address |
| wdata | input | 16 | Write data |
| chip_sel_n | input | 1 | Active-low chip select |
| chip_sel | input | 1 | Active-high chip select |
| wr_n | input | 1 | Active-low write enable |
| rd_oe_n | input | 1 | Active-low output enable |
| lane_en_n | input | 2 | Active-low byte enables; bit 0 lower byte, bit 1 upper byte |
| rd_word | output | 16 | Registered read data |
| lane_drv | output | 2 | Per-lane drive flag (1 = lane driven, 0 = high impedance) |
| in_standby | output | 1 | Registered power state (1 = standby, 0 = active) |

## Verification
The hardest cases to reach from the ports are a write strobe that must do nothing and a write that must happen even though output enable asks for a read. Neither case shows up on the outputs in the cycle it occurs. The stimulus therefore sweeps every combination of the two selects, write enable, output enable and both byte enables onto one word. After each sweep step it reads the word back with both lanes enabled, so a wrongly committed or wrongly blocked byte shows up as a data mismatch against the bench's own reference array. The three deselect conditions are also each tried separately with a write strobe on a word whose contents are known.

// File: rtl/sram_pkg.sv
// Package: shared mode encoding for the byte-lane memory core.
// Assumes: one mode is active per cycle; no state is held here.
package sram_pkg;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_IDLE    = 2'd1,
        MODE_READ    = 2'd2,
        MODE_WRITE   = 2'd3
    } sram_mode_t;

endpackage

// File: rtl/sram_mode_dec.sv
// Module: combinational decode of selects, strobes and byte enables into
// a mode and per-lane write/read strobes.
// Assumes: all control inputs are active-low except chip_sel; write wins
// over output enable.
module sram_mode_dec
    import sram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             chip_sel_n,
    input  logic             chip_sel,
    input  logic             wr_n,
    input  logic             rd_oe_n,
    input  logic [LANES-1:0] lane_en_n,
    output sram_mode_t       mode,
    output logic [LANES-1:0] lane_wr,
    output logic [LANES-1:0] lane_rd
);

    logic selected;

    // Purpose: selected only when both selects agree and some lane is enabled.
    always_comb begin
        selected = !chip_sel_n && chip_sel && !(&lane_en_n);
    end

    // Purpose: pick the mode and gate the per-lane strobes by it.
    always_comb begin
        if (!selected)     mode = MODE_STANDBY;
        else if (!wr_n)    mode = MODE_WRITE;
        else if (!rd_oe_n) mode = MODE_READ;
        else               mode = MODE_IDLE;
        lane_wr = (mode == MODE_WRITE) ? ~lane_en_n : '0;
        lane_rd = (mode == MODE_READ)  ? ~lane_en_n : '0;
    end

endmodule

// File: rtl/sram_lane.sv
// Module: storage and registered read port for one byte lane.
// Assumes: wr and rd are never high together; storage is not reset.
module sram_lane #(
    parameter int LANE_W = 8,
    parameter int MEM_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MEM_AW-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout_q,
    output logic              drv_q
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [LANE_W-1:0] mem [DEPTH];

    // Purpose: commit this lane's byte on a qualified write edge.
    always_ff @(posedge clk) begin
        if (wr) begin
            mem[addr] <= din;
        end
    end

    // Purpose: register read data and drive flag; idle lanes read as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
            drv_q  <= 1'b0;
        end else begin
            dout_q <= rd ? mem[addr] : '0;
            drv_q  <= rd;
        end
    end

endmodule

// File: rtl/sram_core.sv
// Module: top of the byte-lane static memory core. Decodes the mode, fans
// out to one storage lane per byte and registers the power state.
// Assumes: synchronous operation, one request per cycle, address bits above
// MEM_AW are ignored.
module sram_core
    import sram_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    parameter int MEM_AW = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       chip_sel_n,
    input  logic                       chip_sel,
    input  logic                       wr_n,
    input  logic                       rd_oe_n,
    input  logic [DATA_W/LANE_W-1:0]   lane_en_n,
    output logic [DATA_W-1:0]          rd_word,
    output logic [DATA_W/LANE_W-1:0]   lane_drv,
    output logic                       in_standby
);

    localparam int LANES = DATA_W / LANE_W;

    sram_mode_t        mode;
    logic [LANES-1:0]  lane_wr;
    logic [LANES-1:0]  lane_rd;
    logic [MEM_AW-1:0] word_addr;

    // Purpose: keep only the address bits that reach the storage.
    always_comb begin
        word_addr = addr[MEM_AW-1:0];
    end

    sram_mode_dec #(.LANES(LANES)) u_dec (
        .chip_sel_n (chip_sel_n),
        .chip_sel   (chip_sel),
        .wr_n       (wr_n),
        .rd_oe_n    (rd_oe_n),
        .lane_en_n  (lane_en_n),
        .mode       (mode),
        .lane_wr    (lane_wr),
        .lane_rd    (lane_rd)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane #(.LANE_W(LANE_W), .MEM_AW(MEM_AW)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .addr   (word_addr),
            .wr     (lane_wr[g]),
            .rd     (lane_rd[g]),
            .din    (wdata[g*LANE_W +: LANE_W]),
            .dout_q (rd_word[g*LANE_W +: LANE_W]),
            .drv_q  (lane_drv[g])
        );
    end

    // Purpose: register the standby indication alongside the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_standby <= 1'b1;
        end else begin
            in_standby <= (mode == MODE_STANDBY);
        end
    end

endmodule

// File: rtl/sram_core_chk.sv
// Module: port-level property checker for sram_core, bound to every instance.
// Assumes: two byte lanes, as in the default configuration.
module sram_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        chip_sel_n,
    input logic        chip_sel,
    input logic        wr_n,
    input logic        rd_oe_n,
    input logic [1:0]  lane_en_n,
    input logic [15:0] rd_word,
    input logic [1:0]  lane_drv,
    input logic        in_standby
);

    logic sel;
    assign sel = !chip_sel_n && chip_sel && !(&lane_en_n);

    // R1
    deselect_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (in_standby && lane_drv == 2'b00));

    // R2
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_n && !rd_oe_n) |=> (lane_drv == ~$past(lane_en_n) && !in_standby));

    // R3
    lower_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_drv[0] |-> rd_word[7:0] == 8'h00);

    // R3
    upper_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_drv[1] |-> rd_word[15:8] == 8'h00);

    // R4
    write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr_n) |=> (lane_drv == 2'b00 && !in_standby));

    // R6
    idle_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_n && rd_oe_n) |=> (lane_drv == 2'b00 && !in_standby));

endmodule

bind sram_core sram_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_sel_n (chip_sel_n),
    .chip_sel   (chip_sel),
    .wr_n       (wr_n),
    .rd_oe_n    (rd_oe_n),
    .lane_en_n  (lane_en_n),
    .rd_word    (rd_word),
    .lane_drv   (lane_drv),
    .in_standby (in_standby)
);

// File: tb/sim_sram_core.sv
// Bench: scoreboard for sram_core. The driver computes each expected result
// from a reference array and queues it; the monitor compares after each edge.
module sim_sram_core;

    localparam int MEM_AW = 10;

    typedef struct {
        string       tag;
        logic [15:0] data;
        logic [1:0]  drv;
        logic        stby;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        chip_sel_n = 1'b1;
    logic        chip_sel = 1'b0;
    logic        wr_n = 1'b1;
    logic        rd_oe_n = 1'b1;
    logic [1:0]  lane_en_n = 2'b11;
    logic [15:0] rd_word;
    logic [1:0]  lane_drv;
    logic        in_standby;

    logic [15:0] ref_mem [1 << MEM_AW];
    exp_t        q [$];
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    sram_core u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .chip_sel_n(chip_sel_n), .chip_sel(chip_sel), .wr_n(wr_n),
        .rd_oe_n(rd_oe_n), .lane_en_n(lane_en_n), .rd_word(rd_word),
        .lane_drv(lane_drv), .in_standby(in_standby)
    );

    task automatic check(string tag, logic [15:0] d, logic [1:0] v, logic s,
                         logic [15:0] ed, logic [1:0] ev, logic es);
        n_checks++;
        if (d !== ed || v !== ev || s !== es) begin
            n_errors++;
            $display("FAIL %s: got data=%h drv=%b stby=%b, expected data=%h drv=%b stby=%b",
                     tag, d, v, s, ed, ev, es);
        end
    endtask

    // Apply one request for one cycle and queue its expected outcome.
    task automatic op(string tag, logic csn, logic cs, logic wn, logic oen,
                      logic [1:0] en, logic [18:0] a, logic [15:0] d);
        exp_t e;
        logic sel;
        @(negedge clk);
        chip_sel_n = csn; chip_sel = cs; wr_n = wn; rd_oe_n = oen;
        lane_en_n = en; addr = a; wdata = d;
        sel = !csn && cs && !(&en);
        e.tag = tag; e.data = 16'h0; e.drv = 2'b00; e.stby = !sel;
        if (sel && !wn) begin
            if (!en[0]) ref_mem[a[MEM_AW-1:0]][7:0]  = d[7:0];
            if (!en[1]) ref_mem[a[MEM_AW-1:0]][15:8] = d[15:8];
        end else if (sel && !oen) begin
            e.drv = ~en;
            if (!en[0]) e.data[7:0]  = ref_mem[a[MEM_AW-1:0]][7:0];
            if (!en[1]) e.data[15:8] = ref_mem[a[MEM_AW-1:0]][15:8];
        end
        q.push_back(e);
    endtask

    task automatic wr(string tag, logic [1:0] en, logic [18:0] a, logic [15:0] d, logic oen);
        op(tag, 1'b0, 1'b1, 1'b0, oen, en, a, d);
    endtask

    task automatic rd(string tag, logic [1:0] en, logic [18:0] a);
        op(tag, 1'b0, 1'b1, 1'b1, 1'b0, en, a, 16'h0);
    endtask

    // Monitor: compare one queued expectation just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, rd_word, lane_drv, in_standby, e.data, e.drv, e.stby);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R7: outputs held in reset
        repeat (3) @(negedge clk);
        check("R7 reset", rd_word, lane_drv, in_standby, 16'h0, 2'b00, 1'b1);
        // request a read during reset: still reset values
        chip_sel_n = 1'b0; chip_sel = 1'b1; rd_oe_n = 1'b0; lane_en_n = 2'b00;
        @(negedge clk);
        check("R7 reset ignores read", rd_word, lane_drv, in_standby, 16'h0, 2'b00, 1'b1);
        rst_n = 1'b1;
        chip_sel_n = 1'b1;

        // R4: preload, half of them with output enable also low
        for (int i = 0; i < 16; i++)
            wr("R4 preload write", 2'b00, 19'(i), 16'hA500 ^ 16'(i * 16'h1357), 1'(i % 2));
        // R2: full-word reads
        for (int i = 0; i < 16; i++)
            rd("R2 full read", 2'b00, 19'(i));
        // R3: single-lane reads
        rd("R3 lower only read", 2'b10, 19'd2);
        rd("R3 upper only read", 2'b01, 19'd2);
        // R5: masked writes keep the other byte
        wr("R5 lower write", 2'b10, 19'd3, 16'hFFEE, 1'b1);
        rd("R5 after lower write", 2'b00, 19'd3);
        wr("R5 upper write", 2'b01, 19'd4, 16'hDD11, 1'b0);
        rd("R5 after upper write", 2'b00, 19'd4);
        // R9 / R1: write strobes under each deselect condition
        op("R1 R9 csn high", 1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 19'd5, 16'h0BAD);
        op("R1 R9 cs low",   1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 19'd5, 16'h1BAD);
        op("R1 R9 lanes off", 1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 19'd5, 16'h2BAD);
        rd("R9 data kept", 2'b00, 19'd5);
        // R6: selected, no strobe
        op("R6 output disabled", 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 19'd6, 16'h0);
        // R8: upper address bits alias
        wr("R8 alias write", 2'b00, 19'h7FC07, 16'h8E8E, 1'b1);
        rd("R8 alias read", 2'b00, 19'd7);
        rd("R8 alias read high", 2'b00, 19'h00407);
        // Sweep every combination onto word 8, reading it back each time
        for (int c = 0; c < 64; c++) begin
            op("R1 R2 R4 R6 sweep", 1'(c >> 5), 1'(c >> 4), 1'(c >> 3), 1'(c >> 2),
               2'(c), 19'd8, 16'(16'h3C00 + c * 16'h0105));
            rd("R4 R5 R9 sweep readback", 2'b00, 19'd8);
        end
        // Final readback of all preloaded words
        for (int i = 0; i < 16; i++)
            rd("R2 final read", 2'b00, 19'(i));

        @(negedge clk);
        chip_sel_n = 1'b1;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule